// File: doc/BRIEF.md
# Command/Indication Channel Handler

This block sits on a framed time-division serial bus and looks after the two command/indication fields carried in each frame. A data clock running at twice the bit rate and a frame-sync pulse set the timing. The frame has twelve 8-bit slots, and each slot is sent most significant bit first.

On the receive side the block takes two codes from the serial input. The first is a 4-bit primary code, which is only accepted after it has appeared unchanged in two frames in a row. The second is a secondary code, 4 or 6 bits wide, which is accepted as soon as it changes. On the transmit side the block places the host's two transmit codes on the open-drain style serial output in every frame. It drives a 1 in every bit position it does not own.

A small register port gives the host access to the codes, a sticky status register that clears when read, a mask register, and one combined interrupt line.

Top module: `ci_chan_handler`

## Requirements
- R1: A rising edge of `dck_i` with `fsync_i` high starts a frame. Bit k of the frame (k = 0..95, slot k/8, MSB first) is sampled from `din_i` at the (2k+1)-th rising edge of `dck_i` after that edge. Before the first sync, and after a frame has run out without a new sync, nothing is sampled and `dout_o` stays 1.
- R2: The primary receive code is taken from bits 5..2 of slot 3. Reading address 2 returns the primary transmit code in bits 7..4 and the accepted primary receive code in bits 3..0.
- R3: A primary code is accepted only if the same value arrives in two consecutive frames and differs from the accepted code. Acceptance updates the receive code and sets status bit 0.
- R4: A primary code that alternates between two values from one frame to the next never changes the accepted code and never sets status bit 0.
- R5: The secondary code comes from slot 7. Address 3 bit 7 selects the mode (1 = 6-bit, from slot bits 7..2; 0 = 4-bit, from slot bits 7..4, read as {2'b11, bits}). In 4-bit mode, received slot bits 3..0 are ignored. Reading address 3 returns {mode, 0, receive code[5:0]}.
- R6: Any change in the secondary code sets status bit 1 in the same frame, with no confirmation frame.
- R7: In every frame until rewritten, the primary transmit code (address 2, bits 3..0) is driven on slot 3 bits 5..2. The secondary transmit code (address 3, bits 5..0) is driven on slot 7 bits 7..2 in 6-bit mode, or bits 3..0 of it on slot 7 bits 7..4 in 4-bit mode, with 1 on slot bits 3..2. Every other bit is 1.
- R8: Reset sets all receive and transmit codes to all-ones, the mask and status to 0, 4-bit mode, and clears the filter history. The first frame after reset sets no status bit, and loads the secondary receive code silently.
- R9: Status bits (address 0: bit 0 primary, bit 1 secondary) stay set until the host reads address 0, which clears them. An event in the same cycle as that read sets its bit regardless.
- R10: `irq_o` is high while any status bit is set whose mask bit (address 1, bits 1..0) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dck_i | input | 1 | Bus data clock, twice the bit rate, synchronous to clk |
| fsync_i | input | 1 | Frame sync, sampled on a rising edge of dck_i |
| din_i | input | 1 | Serial receive data |
| dout_o | output | 1 | Serial transmit data, 1 = released |
| host_addr_i | input | 2 | Register address |
| host_wr_i | input | 1 | Register write strobe |
| host_rd_i | input | 1 | Register read strobe (a read of address 0 clears status) |
| host_wdata_i | input | 8 | Write data |
| host_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The frame evaluation strobe, which can set a status bit, can land in the same clock cycle as a host read of address 0, which clears the status bits. The bench provokes this by holding the read strobe exactly in the cycle after the last secondary bit is sampled, in a frame where the secondary code changes while the primary status bit is already set. It judges the outcome three ways. The read data must show the old status. The older primary bit must be gone afterwards. The new secondary bit must be present and must drive the interrupt through its mask.

// File: rtl/ci_pkg.sv
package ci_pkg;
    localparam int PRI_W  = 4;   // primary code width
    localparam int SEC_W  = 6;   // secondary code width in wide mode
    localparam int SEC_NW = 4;   // secondary code width in narrow mode
    localparam int PRI_LO = 2;   // primary field low bit inside its slot
    localparam int PRI_HI = 5;   // primary field high bit inside its slot

    typedef struct packed {
        logic [PRI_W-1:0] tx0;
        logic [SEC_W-1:0] tx1;
        logic             wide;
        logic [1:0]       mask;
        logic [PRI_W-1:0] rx0;
        logic [SEC_W-1:0] rx1;
        logic [PRI_W-1:0] cand;
        logic             cand_vld;
        logic             seen;
        logic [1:0]       ist;
    } ci_regs_t;
endpackage

// File: rtl/ci_frame_timer.sv
module ci_frame_timer #(
    parameter int SLOTS  = 12,
    parameter int SLOT_W = 8,
    localparam int NBITS  = SLOTS * SLOT_W,
    localparam int HALVES = 2 * NBITS,
    localparam int CW     = $clog2(HALVES + 1),
    localparam int BW     = $clog2(NBITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dck_i,
    input  logic          fsync_i,
    output logic          active_o,
    output logic          smp_o,
    output logic [BW-1:0] bit_idx_o
);
    localparam logic [CW-1:0] IDLE = CW'(HALVES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          dck;
    } tmr_t;

    tmr_t s_d, s_q;
    logic rise;

    always_comb begin
        s_d  = s_q;
        rise = dck_i & ~s_q.dck;
        s_d.dck = dck_i;
        if (rise) begin
            if (fsync_i)
                s_d.cnt = '0;
            else if (s_q.cnt != IDLE)
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= IDLE;
            s_q.dck <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o  = (s_q.cnt != IDLE);
    assign smp_o     = rise && active_o && !s_q.cnt[0];
    assign bit_idx_o = BW'(s_q.cnt >> 1);
endmodule

// File: rtl/ci_rx_capture.sv
module ci_rx_capture
    import ci_pkg::*;
#(
    parameter int SLOTS    = 12,
    parameter int SLOT_W   = 8,
    parameter int PRI_SLOT = 3,
    parameter int SEC_SLOT = 7,
    localparam int BW = $clog2(SLOTS * SLOT_W),
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_i,
    input  logic [BW-1:0]    bit_idx_i,
    input  logic             din_i,
    output logic [PRI_W-1:0] pri_o,
    output logic [SEC_W-1:0] sec_o,
    output logic             done_o
);
    localparam int SW = BW - PW;
    localparam logic [BW-1:0] LAST = BW'(SEC_SLOT * SLOT_W + SLOT_W - 1);

    typedef struct packed {
        logic [PRI_W-1:0] pri;
        logic [SEC_W-1:0] sec;
        logic             done;
    } cap_t;

    cap_t c_d, c_q;
    logic [SW-1:0] slot;
    logic [PW-1:0] pos;

    assign slot = bit_idx_i[BW-1:PW];
    assign pos  = bit_idx_i[PW-1:0];

    always_comb begin
        c_d = c_q;
        c_d.done = smp_i && (bit_idx_i == LAST);
        if (smp_i && slot == SW'(PRI_SLOT) &&
            pos >= PW'(PRI_LO) && pos <= PW'(PRI_HI))
            c_d.pri = {c_q.pri[PRI_W-2:0], din_i};
        if (smp_i && slot == SW'(SEC_SLOT) && pos < PW'(SEC_W))
            c_d.sec = {c_q.sec[SEC_W-2:0], din_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.pri  <= '1;
            c_q.sec  <= '1;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pri_o  = c_q.pri;
    assign sec_o  = c_q.sec;
    assign done_o = c_q.done;
endmodule

// File: rtl/ci_tx_drive.sv
module ci_tx_drive
    import ci_pkg::*;
#(
    parameter int SLOTS    = 12,
    parameter int SLOT_W   = 8,
    parameter int PRI_SLOT = 3,
    parameter int SEC_SLOT = 7,
    localparam int BW = $clog2(SLOTS * SLOT_W),
    localparam int PW = $clog2(SLOT_W)
) (
    input  logic             active_i,
    input  logic [BW-1:0]    bit_idx_i,
    input  logic [PRI_W-1:0] tx0_i,
    input  logic [SEC_W-1:0] tx1_i,
    input  logic             wide_i,
    output logic             dout_o
);
    localparam int SW = BW - PW;

    logic [SLOT_W-1:0] pri_byte, sec_byte;
    logic [SW-1:0]     slot;
    logic [PW-1:0]     pos;

    assign slot = bit_idx_i[BW-1:PW];
    assign pos  = bit_idx_i[PW-1:0];

    always_comb begin
        pri_byte = '1;
        pri_byte[PRI_HI:PRI_LO] = tx0_i;
        sec_byte = '1;
        if (wide_i)
            sec_byte[SLOT_W-1 -: SEC_W] = tx1_i;
        else
            sec_byte[SLOT_W-1 -: SEC_NW] = tx1_i[SEC_NW-1:0];

        dout_o = 1'b1;
        if (active_i) begin
            if (slot == SW'(PRI_SLOT))
                dout_o = pri_byte[~pos];
            else if (slot == SW'(SEC_SLOT))
                dout_o = sec_byte[~pos];
        end
    end
endmodule

// File: rtl/ci_chan_handler.sv
module ci_chan_handler
    import ci_pkg::*;
#(
    parameter int SLOTS    = 12,
    parameter int SLOT_W   = 8,
    parameter int PRI_SLOT = 3,
    parameter int SEC_SLOT = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dck_i,
    input  logic       fsync_i,
    input  logic       din_i,
    output logic       dout_o,
    input  logic [1:0] host_addr_i,
    input  logic       host_wr_i,
    input  logic       host_rd_i,
    input  logic [7:0] host_wdata_i,
    output logic [7:0] host_rdata_o,
    output logic       irq_o
);
    localparam int BW = $clog2(SLOTS * SLOT_W);

    logic             active, smp, done;
    logic [BW-1:0]    bit_idx;
    logic [PRI_W-1:0] pri_raw;
    logic [SEC_W-1:0] sec_raw, sec_code;
    logic             ev0, ev1, rd_clr;

    ci_regs_t r_d, r_q;

    ci_frame_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .dck_i(dck_i), .fsync_i(fsync_i),
        .active_o(active), .smp_o(smp), .bit_idx_o(bit_idx)
    );

    ci_rx_capture #(.SLOTS(SLOTS), .SLOT_W(SLOT_W),
                    .PRI_SLOT(PRI_SLOT), .SEC_SLOT(SEC_SLOT)) u_cap (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .bit_idx_i(bit_idx),
        .din_i(din_i), .pri_o(pri_raw), .sec_o(sec_raw), .done_o(done)
    );

    ci_tx_drive #(.SLOTS(SLOTS), .SLOT_W(SLOT_W),
                  .PRI_SLOT(PRI_SLOT), .SEC_SLOT(SEC_SLOT)) u_tx (
        .active_i(active), .bit_idx_i(bit_idx), .tx0_i(r_q.tx0),
        .tx1_i(r_q.tx1), .wide_i(r_q.wide), .dout_o(dout_o)
    );

    assign rd_clr   = host_rd_i && (host_addr_i == 2'd0);
    assign sec_code = r_q.wide ? sec_raw
                               : {{(SEC_W-SEC_NW){1'b1}}, sec_raw[SEC_W-1 -: SEC_NW]};

    always_comb begin
        r_d = r_q;
        ev0 = 1'b0;
        ev1 = 1'b0;
        if (done) begin
            // primary: two matching frames in a row before acceptance
            if (r_q.cand_vld && pri_raw == r_q.cand && pri_raw != r_q.rx0) begin
                r_d.rx0 = pri_raw;
                ev0     = 1'b1;
            end
            r_d.cand     = pri_raw;
            r_d.cand_vld = 1'b1;
            // secondary: immediate, silent on the first frame after reset
            if (!r_q.seen) begin
                r_d.rx1  = sec_code;
                r_d.seen = 1'b1;
            end else if (sec_code != r_q.rx1) begin
                r_d.rx1 = sec_code;
                ev1     = 1'b1;
            end
        end
        if (host_wr_i) begin
            case (host_addr_i)
                2'd1: r_d.mask = host_wdata_i[1:0];
                2'd2: r_d.tx0  = host_wdata_i[PRI_W-1:0];
                2'd3: begin
                    r_d.wide = host_wdata_i[7];
                    r_d.tx1  = host_wdata_i[SEC_W-1:0];
                end
                default: ;
            endcase
        end
        if (rd_clr)
            r_d.ist = 2'b00;
        r_d.ist = r_d.ist | {ev1, ev0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.tx0      <= '1;
            r_q.tx1      <= '1;
            r_q.wide     <= 1'b0;
            r_q.mask     <= 2'b00;
            r_q.rx0      <= '1;
            r_q.rx1      <= '1;
            r_q.cand     <= '1;
            r_q.cand_vld <= 1'b0;
            r_q.seen     <= 1'b0;
            r_q.ist      <= 2'b00;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (host_addr_i)
            2'd0:    host_rdata_o = {6'd0, r_q.ist};
            2'd1:    host_rdata_o = {6'd0, r_q.mask};
            2'd2:    host_rdata_o = {r_q.tx0, r_q.rx0};
            default: host_rdata_o = {r_q.wide, 1'b0, r_q.rx1};
        endcase
    end

    assign irq_o = |(r_q.ist & r_q.mask);
endmodule

// File: rtl/ci_chan_handler_chk.sv
module ci_chan_handler_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dout_o,
    input logic       active,
    input logic       done,
    input logic       rd_clr,
    input logic [1:0] ist,
    input logic [3:0] rx0,
    input logic [3:0] cand,
    input logic [5:0] rx1,
    input logic       seen
);
    // R1: released line when no frame is running
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> dout_o);

    // R3: accepted primary code moves only at a frame evaluation
    p_rx0_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx0));

    // R3: a newly accepted primary code equals the previous frame's code
    p_rx0_confirm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rx0 == $past(rx0)) || (rx0 == $past(cand)));

    // R6: a secondary change after the first frame raises its flag
    p_sec_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen) |=> (rx1 == $past(rx1)) || ist[1]);

    // R8: no flag before the first evaluated frame
    p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (ist == 2'b00));

    // R9: status stays set unless read
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ist[0] && !rd_clr) |=> ist[0]);

    // R9: a read outside an evaluation leaves status empty
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !done) |=> (ist == 2'b00));
endmodule

bind ci_chan_handler ci_chan_handler_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dout_o(dout_o), .active(active),
    .done(done), .rd_clr(rd_clr), .ist(r_q.ist), .rx0(r_q.rx0),
    .cand(r_q.cand), .rx1(r_q.rx1), .seen(r_q.seen)
);

// File: tb/sim_ci_chan_handler.sv
module sim_ci_chan_handler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dck = 1'b0, fsync = 1'b0, din = 1'b1;
    logic       dout, irq;
    logic [1:0] haddr = 2'd0;
    logic       hwr = 1'b0, hrd = 1'b0;
    logic [7:0] hwdata = 8'd0, hrdata;

    int ntot = 0, nbad = 0;

    always #10 clk = ~clk;

    ci_chan_handler u0 (
        .clk(clk), .rst_n(rst_n), .dck_i(dck), .fsync_i(fsync), .din_i(din),
        .dout_o(dout), .host_addr_i(haddr), .host_wr_i(hwr), .host_rd_i(hrd),
        .host_wdata_i(hwdata), .host_rdata_o(hrdata), .irq_o(irq)
    );

    // {pri[3:0], sec[5:0], wide, exp_rx0[3:0], exp_rx1[5:0], exp_stat[1:0]}
    localparam logic [22:0] VEC [0:11] = '{
        {4'h5, 6'h0A, 1'b0, 4'hF, 6'h3A, 2'b00},
        {4'h5, 6'h0A, 1'b0, 4'h5, 6'h3A, 2'b01},
        {4'h5, 6'h03, 1'b0, 4'h5, 6'h33, 2'b10},
        {4'h9, 6'h03, 1'b0, 4'h5, 6'h33, 2'b00},
        {4'h6, 6'h03, 1'b0, 4'h5, 6'h33, 2'b00},
        {4'h9, 6'h03, 1'b0, 4'h5, 6'h33, 2'b00},
        {4'h6, 6'h03, 1'b0, 4'h5, 6'h33, 2'b00},
        {4'h6, 6'h03, 1'b0, 4'h6, 6'h33, 2'b01},
        {4'h6, 6'h2D, 1'b1, 4'h6, 6'h2D, 2'b10},
        {4'hA, 6'h2D, 1'b1, 4'h6, 6'h2D, 2'b00},
        {4'hA, 6'h15, 1'b1, 4'hA, 6'h15, 2'b11},
        {4'hA, 6'h15, 1'b1, 4'hA, 6'h15, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntot++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        haddr = a; hwdata = d; hwr = 1'b1;
        @(negedge clk);
        hwr = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        haddr = a; hrd = 1'b1;
        #1 d = hrdata;
        @(negedge clk);
        hrd = 1'b0;
    endtask

    // one full frame; slot 3 and slot 7 carry b3/b7, all else ones
    task automatic run_frame(input logic [7:0] b3, input logic [7:0] b7,
                             input logic rd_eval,
                             output logic [95:0] got, output logic [7:0] evrd);
        logic [95:0] bits;
        bits = '1;
        bits[71 -: 8] = b3;
        bits[39 -: 8] = b7;
        got  = '1;
        evrd = 8'h00;
        for (int p = 0; p < 192; p++) begin
            @(negedge clk);
            dck = 1'b1; fsync = (p == 0); din = bits[95 - (p >> 1)];
            @(negedge clk);
            if (rd_eval && p == 127) begin
                haddr = 2'd0; hrd = 1'b1;
                #1 evrd = hrdata;
            end
            @(negedge clk);
            dck = 1'b0; fsync = 1'b0; hrd = 1'b0;
            if (p % 2 == 1) got[95 - (p >> 1)] = dout;
            @(negedge clk);
        end
    endtask

    task automatic chk_tx(input string req, input logic [95:0] got,
                          input logic [7:0] e3, input logic [7:0] e7);
        logic [95:0] exp;
        exp = '1;
        exp[71 -: 8] = e3;
        exp[39 -: 8] = e7;
        chk(req, got[95:64], exp[95:64]);
        chk(req, got[63:32], exp[63:32]);
        chk(req, got[31:0],  exp[31:0]);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nbad++;
        ntot++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end

    initial begin : main
        logic [7:0]  rd, evrd;
        logic [95:0] got;
        logic [22:0] v;
        logic [7:0]  b3, b7;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        host_rd(2'd0, rd); chk("R8 status after reset", rd, 8'h00);
        host_rd(2'd1, rd); chk("R8 mask after reset", rd, 8'h00);
        host_rd(2'd2, rd); chk("R8 codes0 after reset", rd, 8'hFF);
        host_rd(2'd3, rd); chk("R8 codes1 after reset", rd, 8'h3F);
        chk("R10 irq after reset", irq, 1'b0);
        chk("R1 dout idle after reset", dout, 1'b1);

        // vector table: R3 R4 R5 R6 R8 R9
        for (int i = 0; i < 12; i++) begin
            v = VEC[i];
            host_wr(2'd3, {v[12], 1'b0, 6'h2A});
            b3 = {2'b11, v[22:19], 2'b11};
            b7 = v[12] ? {v[18:13], 2'b11} : {v[16:13], 4'hF};
            run_frame(b3, b7, 1'b0, got, evrd);
            host_rd(2'd2, rd);
            chk($sformatf("R3 R4 vec%0d primary code", i), rd[3:0], v[11:8]);
            host_rd(2'd3, rd);
            chk($sformatf("R5 R6 vec%0d secondary code", i), rd[5:0], v[7:2]);
            host_rd(2'd0, rd);
            chk($sformatf("R9 R8 vec%0d status", i), rd[1:0], v[1:0]);
        end

        // R7 R2: transmit in narrow mode
        host_wr(2'd2, 8'h03);
        host_wr(2'd3, 8'h05);
        run_frame(8'hEB, 8'h5F, 1'b0, got, evrd);
        chk_tx("R7 narrow tx frame", got, 8'hCF, 8'h5F);
        host_rd(2'd2, rd); chk("R2 codes0 readback", rd, 8'h3A);
        host_rd(2'd3, rd); chk("R5 narrow code", rd, 8'h35);
        host_rd(2'd0, rd); chk("R6 narrow change flag", rd, 8'h02);

        // R5: low bits ignored in narrow mode; R7: repeated transmit
        run_frame(8'hEB, 8'h50, 1'b0, got, evrd);
        chk_tx("R7 repeat tx frame", got, 8'hCF, 8'h5F);
        host_rd(2'd3, rd); chk("R5 ignored bits keep code", rd, 8'h35);
        host_rd(2'd0, rd); chk("R5 ignored bits no flag", rd, 8'h00);

        // R7: wide mode transmit
        host_wr(2'd3, 8'hAA);
        run_frame(8'hEB, 8'hD7, 1'b0, got, evrd);
        chk_tx("R7 wide tx frame", got, 8'hCF, 8'hAB);
        host_rd(2'd3, rd); chk("R5 wide readback", rd, 8'hB5);
        host_rd(2'd0, rd); chk("R6 wide no change", rd, 8'h00);

        // R10: mask gating
        run_frame(8'hDB, 8'hD7, 1'b0, got, evrd);
        run_frame(8'hDB, 8'hD7, 1'b0, got, evrd);
        chk("R10 masked flag no irq", irq, 1'b0);
        host_wr(2'd1, 8'h01);
        chk("R10 unmasked primary irq", irq, 1'b1);
        host_wr(2'd1, 8'h02);
        chk("R10 other mask no irq", irq, 1'b0);

        // R9: clearing read in the evaluation cycle
        run_frame(8'hDB, 8'h4B, 1'b1, got, evrd);
        chk("R9 read in eval returns old", evrd, 8'h01);
        chk("R10 irq from new secondary flag", irq, 1'b1);
        host_rd(2'd0, rd); chk("R9 set wins over clear", rd, 8'h02);
        chk("R10 irq after clear", irq, 1'b0);
        host_rd(2'd0, rd); chk("R9 cleared by read", rd, 8'h00);

        // R8: reset again
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk); rst_n = 1'b1;
        host_rd(2'd2, rd); chk("R8 codes0 after second reset", rd, 8'hFF);
        host_rd(2'd3, rd); chk("R8 codes1 after second reset", rd, 8'h3F);

        // R1: no sync, nothing sampled, line released
        begin
            logic hi;
            hi = 1'b1;
            for (int p = 0; p < 50; p++) begin
                @(negedge clk); dck = 1'b1; din = 1'b0;
                @(negedge clk);
                @(negedge clk); dck = 1'b0; hi = hi & dout;
                @(negedge clk);
            end
            chk("R1 dout high without sync", hi, 1'b1);
        end
        host_rd(2'd2, rd); chk("R1 nothing sampled without sync", rd, 8'hFF);
        host_rd(2'd0, rd); chk("R1 no flag without sync", rd, 8'h00);

        // R8: first frame quiet, secondary loaded silently
        run_frame(8'hD7, 8'h0F, 1'b0, got, evrd);
        chk_tx("R8 reset tx codes", got, 8'hFF, 8'hFF);
        host_rd(2'd2, rd); chk("R8 first frame primary held", rd, 8'hFF);
        host_rd(2'd3, rd); chk("R8 first frame secondary loaded", rd, 8'h30);
        host_rd(2'd0, rd); chk("R8 first frame no flag", rd, 8'h00);
        run_frame(8'hD7, 8'h0F, 1'b0, got, evrd);
        host_rd(2'd2, rd); chk("R3 accept on second frame", rd, 8'hF5);
        host_rd(2'd0, rd); chk("R3 flag on acceptance", rd, 8'h01);

        $display("  test done: total=%0d bad=%0d", ntot, nbad);
        $finish;
    end
endmodule